// File: doc/BRIEF.md
# Window Watchdog with Early Warning

This block watches over software that must check in at a regular pace. A 7-bit counter counts down. Each step comes from the system clock divided by a fixed power-of-two stage (4096 by default), followed by a programmable divide by 1, 2, 4 or 8. Once software activates the watchdog, it must reload the counter inside a window. The window lies between a programmable upper value and the fixed lower bound 0x40.

A reload made while the counter is still above the upper value raises a reset request. So does letting the counter step down past 0x40. A reload whose bit 6 is clear also raises one. When the counter reaches 0x40, an early-warning flag is set. If enabled, this flag drives an interrupt so that service code can reload in time.

Software drives the block through a small write port that selects one of three registers. The counter value and the warning flag are visible as outputs.

Top module: `wwin_guard`

## Requirements
- R1: After reset the counter reads 0x7F, the watchdog is inactive, the warning flag, interrupt and reset request are all 0, the window is 0x7F, the prescaler selection is 0 and the interrupt enable is 0.
- R2: A prescale count starts at 0 after reset and rises by one every clock. The counter steps down by one, wrapping from 0x00 to 0x7F, on each clock edge where the low BASE_LOG2+P bits of that count are all ones. P is the prescaler selection. This happens whether or not the watchdog is active.
- R3: A control write (wr_sel=0) loads wr_data[6:0] into the counter on that edge, overriding any step. wr_data[7]=1 activates the watchdog. Activation cannot be undone except by reset.
- R4: While active, a step taken with the counter at 0x40 and no control write on that edge makes rst_req_o high for exactly the following cycle.
- R5: While active, a control write when the counter is above the window value gives a one-cycle reset request in the following cycle. The window value is held in config bits [6:0], written with wr_sel=1. The counter is still loaded.
- R6: A control write with wr_data[6]=0 gives a one-cycle reset request in the following cycle. This applies when the watchdog is already active or when the same write activates it.
- R7: While inactive, and with no activating write, no reset request is ever raised, whatever the counter or window.
- R8: The warning flag is set on the edge where a step moves the counter from 0x41 to 0x40. A status write (wr_sel=2) with wr_data[0]=0 clears it, a status write with wr_data[0]=1 leaves it unchanged, and setting wins over clearing.
- R9: irq_o is high exactly when the warning flag and the interrupt enable are both set. The enable is config bit 9, and once set it can be cleared only by reset. Config bits [8:7] give the prescaler selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 control, 1 config, 2 status, 3 no register |
| wr_data | input | 10 | Write data |
| counter_o | output | 7 | Present counter value |
| warn_flag_o | output | 1 | Early-warning flag |
| irq_o | output | 1 | Early-warning interrupt |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
Directed sequences try the counter under four conditions, each isolating one cause of a reset request. The first is an inactive watchdog, which must stay silent even while it passes 0x40. The second is an early reload above a lowered window. The third is a reload with bit 6 clear under a wide-open window. The fourth is a legal reload left to run out, which must give exactly one pulse. Each of these separates one reset cause from the others. A long random phase then mixes writes to every register, all four prescaler selections and a mid-run reset, and compares every cycle against a reference computed from the requirements. This exposes wrong priorities between a reload and a step on the same edge, and off-by-one errors in the tick spacing.

// File: rtl/wwin_pkg.sv
package wwin_pkg;
  localparam int CNT_W = 7;
  localparam int PSC_W = 2;
  localparam int DATA_W = CNT_W + PSC_W + 1;
  localparam int ACT_BIT = CNT_W;
  localparam int T6_BIT = CNT_W - 1;
  localparam int PSC_LSB = CNT_W;
  localparam int EN_BIT = CNT_W + PSC_W;
  localparam int FLAG_BIT = 0;

  typedef logic [CNT_W-1:0] cnt_t;
  localparam cnt_t LOW_BOUND = cnt_t'(1) << (CNT_W - 1);
  localparam cnt_t CNT_INIT = '1;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_CFG  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } wsel_e;

  // a step is due when the low (base + psc) bits of the count are all ones
  function automatic logic tick_due(input logic [31:0] pre, input int base,
                                    input logic [PSC_W-1:0] psc);
    logic [31:0] mask;
    mask = (32'd1 << (base + int'(psc))) - 32'd1;
    return (pre & mask) == mask;
  endfunction

  function automatic logic refresh_early(input cnt_t cnt, input cnt_t win);
    return cnt > win;
  endfunction
endpackage

// File: rtl/wwin_prescale.sv
module wwin_prescale
  import wwin_pkg::*;
#(
  parameter int BASE_LOG2 = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PSC_W-1:0] psc_i,
  output logic             tick_o
);
  localparam int PRE_W = BASE_LOG2 + (1 << PSC_W) - 1;

  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + 1'b1;
  end

  assign tick_o = tick_due(32'(pre_q), BASE_LOG2, psc_i);

  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
endmodule

// File: rtl/wwin_counter.sv
module wwin_counter
  import wwin_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic load_i,
  input  cnt_t load_val_i,
  output cnt_t cnt_o,
  output logic at_bound_o,
  output logic warn_hit_o
);
  cnt_t cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= CNT_INIT;
    else if (load_i) cnt_q <= load_val_i;
    else if (tick_i) cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o      = cnt_q;
  assign at_bound_o = (cnt_q == LOW_BOUND);
  assign warn_hit_o = tick_i && !load_i && (cnt_q == LOW_BOUND + cnt_t'(1));

  // R2
  dec_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load_i) && (cnt_q != $past(cnt_q))) |-> (cnt_q == cnt_t'($past(cnt_q) - 1'b1)));

  // R3
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == $past(load_val_i)));
endmodule

// File: rtl/wwin_ctrl.sv
module wwin_ctrl
  import wwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tick_i,
  input  cnt_t              cnt_i,
  input  logic              at_bound_i,
  input  logic              warn_hit_i,
  output logic              load_o,
  output cnt_t              load_val_o,
  output logic [PSC_W-1:0]  psc_o,
  output logic              flag_o,
  output logic              irq_o,
  output logic              rst_req_o
);
  logic             active_q, ewi_en_q, flag_q, rst_req_q;
  cnt_t             win_q;
  logic [PSC_W-1:0] psc_q;

  logic ctrl_wr, cfg_wr, stat_wr, flag_clr;
  logic evt_underflow, evt_early, evt_t6;

  assign ctrl_wr = wr_en && (wr_sel == SEL_CTRL);
  assign cfg_wr  = wr_en && (wr_sel == SEL_CFG);
  assign stat_wr = wr_en && (wr_sel == SEL_STAT);
  assign flag_clr = stat_wr && !wr_data[FLAG_BIT];

  assign evt_underflow = active_q && tick_i && at_bound_i && !ctrl_wr;
  assign evt_early     = active_q && ctrl_wr && refresh_early(cnt_i, win_q);
  assign evt_t6        = ctrl_wr && (active_q || wr_data[ACT_BIT]) && !wr_data[T6_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      ewi_en_q  <= 1'b0;
      flag_q    <= 1'b0;
      rst_req_q <= 1'b0;
      win_q     <= CNT_INIT;
      psc_q     <= '0;
    end else begin
      rst_req_q <= evt_underflow || evt_early || evt_t6;
      if (ctrl_wr && wr_data[ACT_BIT]) active_q <= 1'b1;
      if (cfg_wr) begin
        win_q <= wr_data[CNT_W-1:0];
        psc_q <= wr_data[PSC_LSB +: PSC_W];
        if (wr_data[EN_BIT]) ewi_en_q <= 1'b1;
      end
      if (warn_hit_i)    flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end

  assign load_o     = ctrl_wr;
  assign load_val_o = wr_data[CNT_W-1:0];
  assign psc_o      = psc_q;
  assign flag_o     = flag_q;
  assign irq_o      = flag_q && ewi_en_q;
  assign rst_req_o  = rst_req_q;

  // R3
  act_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |=> active_q);

  // R9
  en_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ewi_en_q |=> ewi_en_q);

  // R7
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && !(ctrl_wr && wr_data[ACT_BIT])) |=> !rst_req_o);

  // R8
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> (cnt_i == LOW_BOUND));

  // R4
  under_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && tick_i && (cnt_i == LOW_BOUND) && !ctrl_wr) |=> rst_req_o);
endmodule

// File: rtl/wwin_guard.sv
module wwin_guard
  import wwin_pkg::*;
#(
  parameter int BASE_LOG2 = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [1:0]                 wr_sel,
  input  logic [wwin_pkg::DATA_W-1:0] wr_data,
  output logic [wwin_pkg::CNT_W-1:0]  counter_o,
  output logic                       warn_flag_o,
  output logic                       irq_o,
  output logic                       rst_req_o
);
  logic             tick, load, at_bound, warn_hit;
  cnt_t             load_val, cnt;
  logic [PSC_W-1:0] psc;

  wwin_prescale #(.BASE_LOG2(BASE_LOG2)) u_pre (
    .clk(clk), .rst_n(rst_n), .psc_i(psc), .tick_o(tick)
  );

  wwin_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .load_i(load),
    .load_val_i(load_val), .cnt_o(cnt), .at_bound_o(at_bound),
    .warn_hit_o(warn_hit)
  );

  wwin_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .tick_i(tick), .cnt_i(cnt), .at_bound_i(at_bound),
    .warn_hit_i(warn_hit), .load_o(load), .load_val_o(load_val),
    .psc_o(psc), .flag_o(warn_flag_o), .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  assign counter_o = cnt;
endmodule

// File: tb/wwin_guard_bench.sv
module wwin_guard_bench;
  localparam int BASE = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd3;
  logic [9:0] wr_data = '0;
  logic [6:0] counter_o;
  logic       warn_flag_o, irq_o, rst_req_o;

  int checks = 0;
  int errors = 0;
  bit cmp_on = 1'b0;

  always #10 clk = ~clk;

  wwin_guard #(.BASE_LOG2(BASE)) u_wwin_guard (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .counter_o(counter_o), .warn_flag_o(warn_flag_o),
    .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  // reference state, written from the requirements
  int         m_pre;
  logic [6:0] m_cnt, m_win;
  logic [1:0] m_psc;
  logic       m_act, m_en, m_flag, m_rst;

  function automatic bit step_now(int pre, logic [1:0] psc);
    int period;
    period = 1 << (BASE + psc);
    return (pre % period) == period - 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre = 0; m_cnt = 7'h7F; m_win = 7'h7F; m_psc = 2'd0;
      m_act = 0; m_en = 0; m_flag = 0; m_rst = 0;
    end else begin
      bit st, cw, fw, sw;
      st = step_now(m_pre, m_psc);
      cw = wr_en && wr_sel == 2'd0;
      fw = wr_en && wr_sel == 2'd1;
      sw = wr_en && wr_sel == 2'd2;
      m_rst = (m_act && st && m_cnt == 7'h40 && !cw)
           || (m_act && cw && m_cnt > m_win)
           || (cw && (m_act || wr_data[7]) && !wr_data[6]);
      if (st && !cw && m_cnt == 7'h41) m_flag = 1;
      else if (sw && !wr_data[0])      m_flag = 0;
      if (cw) begin
        m_cnt = wr_data[6:0];
        if (wr_data[7]) m_act = 1;
      end else if (st) m_cnt = m_cnt - 7'd1;
      if (fw) begin
        m_win = wr_data[6:0];
        m_psc = wr_data[8:7];
        if (wr_data[9]) m_en = 1;
      end
      m_pre = m_pre + 1;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      chk("R2 counter", counter_o, m_cnt);
      chk("R4 reset request", rst_req_o, m_rst);
      chk("R8 warning flag", warn_flag_o, m_flag);
      chk("R9 interrupt", irq_o, m_flag & m_en);
    end
  end

  task automatic wr(logic [1:0] sel, logic [9:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_sel = 2'd3;
  endtask

  task automatic count_pulses(int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (rst_req_o) n++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 counter", counter_o, 7'h7F);
    chk("R1 flag", warn_flag_o, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 rst_req", rst_req_o, 0);
    cmp_on = 1'b1;

    // R3 load while inactive, overriding any step
    wr(2'd0, 10'h055);
    chk("R3 loaded value", counter_o, 7'h55);

    // R7 inactive run through 0x40, also a T6-clear load while inactive
    wr(2'd0, 10'h041);
    count_pulses(24, n);
    chk("R7 no pulses while inactive", n, 0);
    wr(2'd0, 10'h020);
    chk("R7 inactive T6-clear write", rst_req_o, 0);
    chk("R8 flag set after 0x40", warn_flag_o, 1);
    chk("R9 irq off while disabled", irq_o, 0);

    // R8 status write with bit0=1 keeps the flag
    wr(2'd2, 10'h001);
    chk("R8 keep on bit0=1", warn_flag_o, 1);
    // R9 enable the interrupt
    wr(2'd1, 10'h27F);
    chk("R9 irq on", irq_o, 1);
    wr(2'd1, 10'h07F);
    chk("R9 enable sticky", irq_o, 1);
    wr(2'd2, 10'h000);
    chk("R8 cleared by bit0=0", warn_flag_o, 0);
    chk("R9 irq follows flag", irq_o, 0);

    // R3 activate; R5 early refresh above a lowered window
    wr(2'd0, 10'h0FF);
    chk("R3 activation write quiet", rst_req_o, 0);
    wr(2'd1, 10'h260);
    wr(2'd0, 10'h07F);
    chk("R5 early refresh pulse", rst_req_o, 1);
    @(negedge clk);
    chk("R5 pulse one cycle", rst_req_o, 0);

    // R6 T6-clear refresh with a wide window
    wr(2'd1, 10'h27F);
    wr(2'd0, 10'h030);
    chk("R6 T6 clear pulse", rst_req_o, 1);

    // R4 legal refresh then run out
    wr(2'd0, 10'h042);
    chk("R4 legal refresh quiet", rst_req_o, 0);
    count_pulses(20, n);
    chk("R4 exactly one underflow pulse", n, 1);

    // R3 activation survives a write with bit7=0
    wr(2'd0, 10'h044);
    count_pulses(20, n);
    chk("R3 still active after bit7=0 write", n, 1);

    // random phase
    for (int k = 0; k < 6000; k++) begin
      @(negedge clk);
      if (k == 3000) begin
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
      end
      if ($urandom % 8 == 0) begin
        logic [1:0] s;
        logic [9:0] d;
        s = 2'($urandom % 4);
        d = 10'($urandom);
        if (s == 2'd0 && ($urandom % 4 != 0)) d[6] = 1'b1;
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'd3;
      end
    end

    do_reset();
    @(negedge clk);
    chk("R1 counter after late reset", counter_o, 7'h7F);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule